// File: doc/BRIEF.md
# Bit-Serial Time-Shared FIR Filter

This block is a 32-tap finite impulse response filter for low sample rates. It uses one bit-serial multiplier for every tap in turn. Samples are signed 8-bit values and coefficients are signed 8-bit constants. The coefficients are computed when the block is elaborated, so they cannot be changed at run time.

Each accepted sample overwrites the oldest entry in a 32-deep circular history. A tap counter then walks the history from the newest sample to the oldest and selects the matching coefficient for each position. The chosen sample is loaded into a parallel-to-serial shifter. Its bits are fed most significant first into a shift-and-add multiplier, which gives one clock per data bit. Each finished product is added to an accumulator. When the last tap is done, the sum is presented on the output.

A sample therefore costs TAPS × DATA_W clocks (256 with the defaults). The sample rate falls in proportion to the filter length, while the amount of logic stays almost the same. Longer filters can be built by running several instances side by side and adding their outputs.

The input and output are valid/ready streams, with these back-pressure rules:
- The block takes one sample, then drops `in_ready` until its result has been taken at the output.
- Any `in_valid` seen while `in_ready` is low is not accepted, and the data on `in_data` has no effect.
- The result stays on `out_data` with `out_valid` high until `out_ready` is seen.

Top module: `serial_fir`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, and every history entry is zero. The first outputs therefore only see the samples sent since reset.
- R2: `in_ready` is 1 only while the block is idle. It falls in the cycle after a handshake. While `in_ready` is 0, `in_valid` and `in_data` leave the history and all later outputs unchanged.
- R3: Each output equals the sum over k = 0..31 of c[k]·x[n−k], where x[n] is the newest accepted sample. The coefficients are c[k] = (5k² + 3k + 1) mod 256, read as signed 8-bit two's complement. The result is a signed 21-bit two's complement value on `out_data`.
- R4: Samples are signed two's complement, and the sample's MSB carries negative weight. Full-scale −128 and +127 inputs give exact products.
- R5: `out_valid` rises exactly TAPS·DATA_W = 256 clock edges after the edge on which the sample was accepted.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold. After the edge where both are 1, `out_valid` is 0 and `in_ready` is 1.
- R7: The history is a 32-sample window. Once more than 32 samples have been accepted, the oldest sample no longer affects the output.
- R8: A single sample of amplitude A followed by zeros produces the outputs A·c[0], A·c[1], … A·c[31], and then zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block idle and able to accept a sample |
| in_data | input | 8 | Signed input sample |
| out_valid | output | 1 | Filter result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 21 | Signed filter result |

## Verification
On every cycle, the checker enforces the handshake rules:
- `in_ready` is low while a result is waiting, and it drops after each accept.
- A held result does not change, and a taken result clears.
- A counter confirms that the result appears exactly 256 clocks after each accept.

The arithmetic can only be shown by the bench's scenarios, scored against a reference model written independently of the RTL:
- the coefficient values and the newest-first tap order, through an impulse;
- the negative weight of the sample MSB, through full-scale samples;
- the dropping of samples older than 32;
- the lack of any effect from input offered while the block is busy.

// File: rtl/sfir_pkg.sv
package sfir_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } sfir_state_e;

  // Fixed coefficient rule: (5k^2 + 3k + 1) mod 2^w, read as w-bit two's complement.
  function automatic int coef_of(input int k, input int w);
    int m;
    m = 1 << w;
    return (5 * k * k + 3 * k + 1) % m;
  endfunction

endpackage

// File: rtl/sfir_ring.sv
module sfir_ring #(
  parameter int DATA_W = 8,
  parameter int TAPS   = 32,
  localparam int AW    = $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_age,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [TAPS];
  logic [AW-1:0]     wptr;
  logic [AW-1:0]     newest;
  logic [AW-1:0]     raddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr   <= '0;
      newest <= '0;
      for (int i = 0; i < TAPS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wptr] <= wr_data;
      newest    <= wptr;
      wptr      <= wptr + AW'(1);
    end
  end

  // Age 0 is the newest sample; the address wraps modulo TAPS.
  assign raddr   = newest - rd_age;
  assign rd_data = mem[raddr];

endmodule

// File: rtl/sfir_ctrl.sv
module sfir_ctrl #(
  parameter int DATA_W = 8,
  parameter int TAPS   = 32,
  localparam int AW    = $clog2(TAPS),
  localparam int BW    = $clog2(DATA_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          accept,
  output logic          step,
  output logic          first_bit,
  output logic          last_bit,
  output logic          load_next,
  output logic          finish,
  output logic [AW-1:0] tap,
  output logic [AW-1:0] next_age,
  output logic          out_valid
);
  import sfir_pkg::*;

  localparam logic [BW-1:0] BIT_TOP = BW'(DATA_W - 1);
  localparam logic [AW-1:0] TAP_TOP = AW'(TAPS - 1);

  sfir_state_e   state;
  logic [BW-1:0] bit_cnt;
  logic [AW-1:0] tap_cnt;
  logic          last_tap;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_HOLD);
  assign accept    = in_ready && in_valid;
  assign step      = (state == ST_RUN);
  assign first_bit = (bit_cnt == BIT_TOP);
  assign last_bit  = (bit_cnt == '0);
  assign last_tap  = (tap_cnt == TAP_TOP);
  assign load_next = step && last_bit && !last_tap;
  assign finish    = step && last_bit && last_tap;
  assign tap       = tap_cnt;
  assign next_age  = tap_cnt + AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= BIT_TOP;
      tap_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (in_valid) begin
          state   <= ST_RUN;
          bit_cnt <= BIT_TOP;
          tap_cnt <= '0;
        end
        ST_RUN: begin
          if (last_bit) begin
            bit_cnt <= BIT_TOP;
            if (last_tap) state <= ST_HOLD;
            else          tap_cnt <= tap_cnt + AW'(1);
          end else begin
            bit_cnt <= bit_cnt - BW'(1);
          end
        end
        ST_HOLD: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sfir_mac.sv
module sfir_mac #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 21,
  localparam int PW    = DATA_W + COEF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] start_data,
  input  logic              step,
  input  logic              first_bit,
  input  logic              last_bit,
  input  logic              load_next,
  input  logic [DATA_W-1:0] next_data,
  input  logic [COEF_W-1:0] coef,
  input  logic              finish,
  output logic [ACC_W-1:0]  result
);

  logic [DATA_W-1:0] shreg;
  logic [PW-1:0]     prod;
  logic [PW-1:0]     cx;
  logic [PW-1:0]     addend;
  logic [PW-1:0]     base;
  logic [PW-1:0]     prod_nxt;
  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  psum;

  // Shift-and-add, MSB first: the MSB step subtracts the coefficient.
  always_comb begin
    cx       = {{DATA_W{coef[COEF_W-1]}}, coef};
    base     = first_bit ? '0 : (prod << 1);
    if (!shreg[DATA_W-1]) addend = '0;
    else if (first_bit)   addend = '0 - cx;
    else                  addend = cx;
    prod_nxt = base + addend;
    psum     = acc + {{(ACC_W-PW){prod_nxt[PW-1]}}, prod_nxt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      prod   <= '0;
      acc    <= '0;
      result <= '0;
    end else begin
      if (start) begin
        shreg <= start_data;
        acc   <= '0;
      end else if (step) begin
        prod  <= prod_nxt;
        shreg <= load_next ? next_data : (shreg << 1);
        if (last_bit) acc <= psum;
      end
      if (finish) result <= psum;
    end
  end

endmodule

// File: rtl/serial_fir.sv
module serial_fir #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int TAPS   = 32,
  localparam int AW    = $clog2(TAPS),
  localparam int ACC_W = DATA_W + COEF_W + AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ACC_W-1:0]  out_data
);

  logic              accept, step, first_bit, last_bit, load_next, finish;
  logic [AW-1:0]     tap, next_age;
  logic [DATA_W-1:0] ring_rd;
  logic [COEF_W-1:0] rom [TAPS];
  logic [COEF_W-1:0] coef;

  for (genvar i = 0; i < TAPS; i++) begin : g_rom
    assign rom[i] = COEF_W'(sfir_pkg::coef_of(i, COEF_W));
  end
  assign coef = rom[tap];

  sfir_ctrl #(.DATA_W(DATA_W), .TAPS(TAPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .accept(accept), .step(step), .first_bit(first_bit),
    .last_bit(last_bit), .load_next(load_next), .finish(finish), .tap(tap),
    .next_age(next_age), .out_valid(out_valid)
  );

  sfir_ring #(.DATA_W(DATA_W), .TAPS(TAPS)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_data(in_data),
    .rd_age(next_age), .rd_data(ring_rd)
  );

  sfir_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_data(in_data),
    .step(step), .first_bit(first_bit), .last_bit(last_bit),
    .load_next(load_next), .next_data(ring_rd), .coef(coef),
    .finish(finish), .result(out_data)
  );

endmodule

// File: rtl/sfir_checker.sv
module sfir_checker #(
  parameter int DATA_W = 8,
  parameter int TAPS   = 32,
  parameter int ACC_W  = 21,
  localparam int LAT   = TAPS * DATA_W,
  localparam int LW    = $clog2(LAT + 1) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ACC_W-1:0] out_data
);

  logic          armed;
  logic [LW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (in_valid && in_ready) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (armed && !out_valid) begin
      cnt <= cnt + LW'(1);
    end else if (out_valid) begin
      armed <= 1'b0;
    end
  end

  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (armed && cnt == LW'(LAT)));

  assert_no_early_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !out_valid) |-> (cnt < LW'(LAT)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));

endmodule

bind serial_fir sfir_checker #(.DATA_W(DATA_W), .TAPS(TAPS), .ACC_W(ACC_W)) u_sfir_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/test_serial_fir.sv
`timescale 1ns/1ps
module test_serial_fir;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_data;
  logic        out_valid;
  logic        out_ready;
  logic [20:0] out_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int hist [32];
  int exp_q [$];
  int acc_q [$];
  string tag_q [$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_fir i_serial_fir (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic int cf(input int k);
    int v;
    v = (5 * k * k + 3 * k + 1) % 256;
    return (v >= 128) ? v - 256 : v;
  endfunction

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic send(input int x, input string tag);
    int e;
    e = 0;
    for (int k = 31; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    for (int k = 0; k < 32; k++) e += cf(k) * hist[k];
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'(x);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    acc_q.push_back(cyc);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: scoreboard compare, latency, hold under stall, release.
  initial begin
    bit seen;
    int held, stall_left, n_out;
    seen = 0; held = 0; stall_left = 0; n_out = 0;
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (out_valid && !seen) begin
        int e, a;
        string t;
        seen = 1;
        held = int'($signed(out_data));
        if (exp_q.size() == 0) begin
          check(0, "R3 unexpected output", held, 0);
        end else begin
          e = exp_q.pop_front();
          a = acc_q.pop_front();
          t = tag_q.pop_front();
          check(held == e, {t, " out_data"}, held, e);
          check(cyc - a == 256, "R5 latency", cyc - a, 256);
        end
        stall_left = n_out % 4;
        n_out++;
        out_ready = (stall_left == 0);
      end else if (out_valid && seen) begin
        check(int'($signed(out_data)) == held, "R6 held data", int'($signed(out_data)), held);
        if (stall_left > 0) stall_left--;
        out_ready = (stall_left == 0);
      end else begin
        if (seen) check(in_ready == 1'b1, "R6 ready after release", int'(in_ready), 1);
        seen = 0;
        out_ready = 1'b0;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lcg;
    for (int k = 0; k < 32; k++) hist[k] = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);

    // R8 / R1: impulse into zero history walks the coefficients newest first
    send(100, "R8 impulse");
    for (int i = 0; i < 33; i++) send(0, "R8 tail");

    // R4: full-scale negative and positive samples
    for (int i = 0; i < 5; i++) send(-128, "R4 neg full scale");
    for (int i = 0; i < 3; i++) send(127, "R4 pos full scale");
    send(-1, "R4 minus one");

    // R2: input offered while busy is not taken
    send(37, "R3 before busy");
    repeat (20) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      in_valid = 1'b1;
      in_data  = 8'h55;
      check(in_ready == 1'b0, "R2 busy ready low", int'(in_ready), 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    send(-9, "R2 busy strobe ignored");

    // R3 / R7: long mixed stream wraps the history window
    lcg = 12345;
    for (int i = 0; i < 40; i++) begin
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      send(((lcg >> 8) & 255) - 128, "R7 window");
    end
    for (int i = 0; i < 32; i++) send(3, "R3 constant");

    wait (exp_q.size() == 0);
    repeat (10) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule